// File: doc/BRIEF.md
# Serial-Loaded Switch Enable Register

This block is the digital control core of an eight-way switch array. A host writes it over a three-wire serial link made of an active-low frame select, a serial clock and a data line. The block runs on a fast system clock and brings all serial pins into that domain through two-flop synchronizers. It detects serial clock edges there, so the serial clock must run at no more than a quarter of the system clock.

While the frame select is low, data bits are shifted into an 8-bit register on each falling serial clock edge. A chain output presents the register MSB and advances on each rising serial clock edge, so several blocks can be cascaded. The rising edge of frame select latches the register as the new switch word.

The latched word is applied with break-before-make sequencing. Switches leaving the on state drop first. Switches joining it rise only after a programmable gap. Switches that stay on are never interrupted. An active-low clear pin and the system reset force every switch off.

Top module: `swctl_top`

## Requirements
- R1: After reset, and within four system clocks of the clear pin going low, every switch enable, the busy flag and the chain output are 0. The shift register is also emptied, so the next frame's chain output reads back 8'h00.
- R2: A frame is sent MSB first. After an 8-bit frame, the first bit sent drives sw_en[7] and the last drives sw_en[0]. A 1 closes a switch.
- R3: While frame select is high, toggling the serial clock and data changes neither the shift register nor the enables.
- R4: A frame of any length leaves the last 8 bits shifted in. Longer frames drop their earliest bits. Shorter frames move the previous contents up.
- R5: The enables change only after a rising edge of frame select. They do not change while a frame is being shifted.
- R6: chain_out changes only on a rising serial clock edge while frame select is low. Over an 8-bit frame, it replays the previous register contents MSB first.
- R7: On an update, the enables first take the value old AND new, with busy high. After exactly GAP_CYC system clocks at that value they take the new word, and busy falls. No switch turns on in the same cycle that another turns off.
- R8: A switch that is on in both the old and the new word stays on in every cycle of the update.
- R9: A frame-select rising edge during a gap replaces the pending word. Sequencing restarts from the enables as currently applied. busy stays high until the enables equal the newest word.
- R10: Any word is accepted, including all ones and all zeros. An update that only opens switches has no gap and never raises busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_n_pin | input | 1 | Frame select from the serial link, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock, asynchronous |
| din_pin | input | 1 | Serial data in, asynchronous |
| clr_n_pin | input | 1 | Active-low clear, asynchronous |
| chain_out | output | 1 | Cascade data output (register MSB) |
| sw_en | output | NUM_SW | Switch enables, bit i closes switch i+1 |
| busy | output | 1 | High while a break-before-make gap is running |

## Verification
The bench watches every system clock of each update. It catches a sequencer that closes new switches before opening old ones, briefly drops a switch kept on, or miscounts the gap length. It loads words that only add switches, words that only remove them, and all-ones and all-zeros words. A design that still gated busy on a gap-free update would show busy cycles there. The bench toggles the serial pins with frame select high, and sends 12-bit and 4-bit frames. A register that shifted while idle, or that truncated rather than kept the last eight bits, would latch the wrong word. A second latch inside a running gap exposes a sequencer that finishes the stale word, or briefly lowers busy, before it applies the newest one.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

    localparam int SW_COUNT_DEF   = 8;
    localparam int GAP_CYC_DEF    = 4;
    localparam int SYNC_STAGE_DEF = 2;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_GAP  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t detect_edge(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
    parameter int             W      = 4,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= {STAGES{IDLE[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[g]};
            end
        end
        assign sync_out[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/swctl_shifter.sv
module swctl_shifter
    import swctl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         fs_n_s,
    input  logic         sclk_s,
    input  logic         din_s,
    output logic [W-1:0] word,
    output logic         dout,
    output logic         latch
);

    logic [W-1:0] sreg_q;
    logic         fs_prev_q;
    logic         sclk_prev_q;
    logic         dout_q;
    logic         active;
    edge_t        sclk_e;
    edge_t        fs_e;

    assign sclk_e = detect_edge(sclk_s, sclk_prev_q);
    assign fs_e   = detect_edge(fs_n_s, fs_prev_q);
    assign active = ~fs_n_s;

    always_ff @(posedge clk) begin
        if (clr) begin
            sreg_q      <= '0;
            dout_q      <= 1'b0;
            fs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            fs_prev_q   <= fs_n_s;
            sclk_prev_q <= sclk_s;
            if (active && sclk_e.fall) begin
                sreg_q <= {sreg_q[W-2:0], din_s};
            end
            if (active && sclk_e.rise) begin
                dout_q <= sreg_q[W-1];
            end
        end
    end

    assign word  = sreg_q;
    assign dout  = dout_q;
    assign latch = fs_e.rise & ~clr;

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (clr) fs_n_s |=> $stable(sreg_q)); // R3
    AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (clr) !(active && sclk_e.rise) |=> $stable(dout_q)); // R6

endmodule

// File: rtl/swctl_bbm.sv
module swctl_bbm
    import swctl_pkg::*;
#(
    parameter int W   = 8,
    parameter int GAP = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic [W-1:0] en,
    output logic         busy
);

    localparam int CW = $clog2(GAP + 1);

    seq_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  target_q;
    logic [W-1:0]  en_q;
    logic          need_on;

    assign need_on = |(word & ~en_q);

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q  <= SEQ_IDLE;
            cnt_q    <= '0;
            target_q <= '0;
            en_q     <= '0;
        end else if (load) begin
            target_q <= word;
            en_q     <= en_q & word;
            if (need_on) begin
                state_q <= SEQ_GAP;
                cnt_q   <= CW'(GAP);
            end else begin
                state_q <= SEQ_IDLE;
            end
        end else if (state_q == SEQ_GAP) begin
            if (cnt_q == CW'(1)) begin
                en_q    <= target_q;
                state_q <= SEQ_IDLE;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign en   = en_q;
    assign busy = (state_q == SEQ_GAP);

    AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (clr) (|(en_q & ~$past(en_q))) |-> !(|($past(en_q) & ~en_q))); // R7
    AST_MAKE_AFTER_GAP: assert property (@(posedge clk) disable iff (clr) (|(en_q & ~$past(en_q))) |-> $fell(busy)); // R7
    AST_KEEP_ON: assert property (@(posedge clk) disable iff (clr) !(|($past(en_q) & target_q & ~en_q))); // R8
    AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (clr) !busy |-> (en_q == target_q)); // R9

endmodule

// File: rtl/swctl_top.sv
module swctl_top
    import swctl_pkg::*;
#(
    parameter int NUM_SW      = SW_COUNT_DEF,
    parameter int GAP_CYC     = GAP_CYC_DEF,
    parameter int SYNC_STAGES = SYNC_STAGE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_n_pin,
    input  logic              sclk_pin,
    input  logic              din_pin,
    input  logic              clr_n_pin,
    output logic              chain_out,
    output logic [NUM_SW-1:0] sw_en,
    output logic              busy
);

    localparam int          NPIN     = 4;
    localparam logic [3:0]  PIN_IDLE = 4'b1100;

    logic [NPIN-1:0]   pins_raw;
    logic [NPIN-1:0]   pins_s;
    logic              clr;
    logic [NUM_SW-1:0] shift_word;
    logic              latch;

    assign pins_raw = {clr_n_pin, fs_n_pin, sclk_pin, din_pin};

    swctl_sync #(
        .W      (NPIN),
        .STAGES (SYNC_STAGES),
        .IDLE   (PIN_IDLE)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    assign clr = rst | ~pins_s[3];

    swctl_shifter #(
        .W (NUM_SW)
    ) shifter_i (
        .clk    (clk),
        .clr    (clr),
        .fs_n_s (pins_s[2]),
        .sclk_s (pins_s[1]),
        .din_s  (pins_s[0]),
        .word   (shift_word),
        .dout   (chain_out),
        .latch  (latch)
    );

    swctl_bbm #(
        .W   (NUM_SW),
        .GAP (GAP_CYC)
    ) bbm_i (
        .clk  (clk),
        .clr  (clr),
        .load (latch),
        .word (shift_word),
        .en   (sw_en),
        .busy (busy)
    );

    AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (rst) !pins_s[3] |=> (sw_en == '0 && !busy && !chain_out)); // R1

endmodule

// File: tb/swctl_top_tb_top.sv
module swctl_top_tb_top;

    localparam int GAP_CYC = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fs_n_pin = 1'b1;
    logic       sclk_pin = 1'b0;
    logic       din_pin = 1'b0;
    logic       clr_n_pin = 1'b1;
    logic       chain_out;
    logic [7:0] sw_en;
    logic       busy;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;
    bit  mon_on = 0;
    bit  mon_saw_stale = 0;
    bit  mon_saw_idle = 0;

    always #2 clk = ~clk;

    swctl_top #(.NUM_SW(8), .GAP_CYC(GAP_CYC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .fs_n_pin(fs_n_pin), .sclk_pin(sclk_pin),
        .din_pin(din_pin), .clr_n_pin(clr_n_pin), .chain_out(chain_out),
        .sw_en(sw_en), .busy(busy)
    );

    always @(negedge clk) begin
        if (mon_on) begin
            if (sw_en == 8'hC6) mon_saw_stale = 1;
            if (!busy) mon_saw_idle = 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n, output logic [7:0] seen);
        seen = '0;
        for (int i = n - 1; i >= 0; i--) begin
            din_pin = bits[i];
            sclk_pin = 1'b1;
            wait_clk(4);
            seen = {seen[6:0], chain_out};
            sclk_pin = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic frame(input logic [31:0] bits, input int n, output logic [7:0] seen);
        fs_n_pin = 1'b0;
        wait_clk(4);
        shift_bits(bits, n, seen);
        wait_clk(2);
        fs_n_pin = 1'b1;
    endtask

    task automatic observe(input logic [7:0] oldw, input logic [7:0] neww, input string tag);
        logic [7:0] mid;
        int  busy_n;
        bit  bad;
        bit  keep_bad;
        bit  done;
        int  exp_gap;
        mid = oldw & neww;
        busy_n = 0; bad = 0; keep_bad = 0; done = 0;
        exp_gap = (|(neww & ~oldw)) ? GAP_CYC : 0;
        for (int c = 0; c < GAP_CYC + 12; c++) begin
            @(negedge clk);
            if ((sw_en & mid) != mid) keep_bad = 1;
            if (busy) begin
                busy_n++;
                if (sw_en != mid || done) bad = 1;
            end else if (sw_en == neww) begin
                done = 1;
            end else if (sw_en != oldw || done) begin
                bad = 1;
            end
        end
        check(!bad, "R7", {tag, " break-before-make order"}, sw_en, neww);
        check(busy_n == exp_gap, "R7", {tag, " gap length"}, busy_n, exp_gap);
        check(!keep_bad, "R8", {tag, " kept switches held"}, sw_en, mid);
        check(sw_en == neww && !busy, "R2", {tag, " final enables"}, sw_en, neww);
        wait_clk(1);
    endtask

    task automatic t_reset();
        check(sw_en == 8'h00, "R1", "enables after reset", sw_en, 0);
        check(!busy && !chain_out, "R1", "busy/chain after reset", {busy, chain_out}, 0);
    endtask

    task automatic t_basic();
        logic [7:0] seen;
        frame(8'hA5, 8, seen);
        check(seen == 8'h00, "R6", "chain replay of empty register", seen, 8'h00);
        observe(8'h00, 8'hA5, "first word");
        check(sw_en[7] && sw_en[0] && !sw_en[6], "R2", "bit order MSB->switch 8", sw_en, 8'hA5);
        frame(8'h3C, 8, seen);
        check(seen == 8'hA5, "R6", "chain replays previous word", seen, 8'hA5);
        observe(8'hA5, 8'h3C, "mixed word");
    endtask

    task automatic t_all_none();
        logic [7:0] seen;
        frame(8'hFF, 8, seen);
        observe(8'h3C, 8'hFF, "R10 all on");
        frame(8'h00, 8, seen);
        check(seen == 8'hFF, "R6", "chain replays all-ones", seen, 8'hFF);
        observe(8'hFF, 8'h00, "R10 all off");
    endtask

    task automatic t_idle_ignore();
        logic [7:0] seen;
        frame(8'h5A, 8, seen);
        observe(8'h00, 8'h5A, "pre R3");
        din_pin = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sclk_pin = 1'b1; wait_clk(4);
            sclk_pin = 1'b0; wait_clk(4);
        end
        fs_n_pin = 1'b0; wait_clk(4);
        fs_n_pin = 1'b1; wait_clk(GAP_CYC + 10);
        check(sw_en == 8'h5A, "R3", "idle toggles ignored", sw_en, 8'h5A);
        fs_n_pin = 1'b0; wait_clk(4);
        shift_bits(8'hC3, 8, seen);
        check(sw_en == 8'h5A, "R5", "enables hold during frame", sw_en, 8'h5A);
        check(seen == 8'h5A, "R3", "register untouched while idle", seen, 8'h5A);
        wait_clk(2);
        fs_n_pin = 1'b1;
        observe(8'h5A, 8'hC3, "after hold");
    endtask

    task automatic t_lengths();
        logic [7:0] seen;
        frame(32'hABC, 12, seen);
        observe(8'hC3, 8'hBC, "R4 long frame");
        frame(32'h6, 4, seen);
        observe(8'hBC, 8'hC6, "R4 short frame");
    endtask

    task automatic t_relatch();
        logic [7:0] seen;
        int run;
        frame(8'h39, 8, seen);
        observe(8'hC6, 8'h39, "pre R9");
        fs_n_pin = 1'b0; wait_clk(4);
        shift_bits(8'hC6, 8, seen);
        wait_clk(2);
        fs_n_pin = 1'b1;
        wait_clk(6);
        mon_saw_stale = 0; mon_saw_idle = 0; mon_on = 1;
        check(busy && sw_en == 8'h00, "R9", "first latch opened switches", sw_en, 8'h00);
        fs_n_pin = 1'b0; wait_clk(4);
        shift_bits(32'h1, 1, seen);
        wait_clk(2);
        fs_n_pin = 1'b1;
        run = 0;
        while (run < GAP_CYC + 20) begin
            @(negedge clk);
            if (!busy) break;
            run++;
        end
        mon_on = 0;
        check(!mon_saw_stale, "R9", "stale word never applied", 1, 0);
        check(run >= GAP_CYC, "R9", "gap restarted at second latch", run, GAP_CYC);
        check(sw_en == 8'h8D && !busy, "R9", "newest word applied", sw_en, 8'h8D);
        wait_clk(GAP_CYC);
        check(sw_en == 8'h8D && !busy, "R9", "enables settled", sw_en, 8'h8D);
    endtask

    task automatic t_clear();
        logic [7:0] seen;
        clr_n_pin = 1'b0;
        wait_clk(4);
        check(sw_en == 8'h00 && !busy, "R1", "clear pin opens all", sw_en, 0);
        clr_n_pin = 1'b1;
        wait_clk(4);
        frame(8'h12, 8, seen);
        check(seen == 8'h00, "R1", "clear emptied register", seen, 0);
        observe(8'h00, 8'h12, "after clear");
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_basic();
        t_all_none();
        t_idle_ignore();
        t_lengths();
        t_relatch();
        t_clear();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R1-R10 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule